// File: doc/BRIEF.md
# OAM Cell Builder with CRC-10 Insertion

This block assembles one ATM cell for operations-and-maintenance traffic from one 48-octet buffer. The cell has four header octets and no HEC. A descriptor is accepted with a valid/ready handshake. It carries a 32-bit header template and the option fields that control the cell: a buffer option, an adaptation mode, begin and end message bits, a header-rewrite enable, replacement VCI and PTI values, a CRC enable and a status-redirect enable. The block then emits a 52-octet byte stream. The header comes first, most significant octet first, and the payload octets follow, taken one for one from the input payload stream.

When header rewriting is enabled, the VCI and PTI fields of the template are replaced. This produces F4 flow cells (VCI 3 for segment, 4 for end-to-end) or F5 flow cells (PTI 100 for segment, 101 for end-to-end). When the CRC is enabled, the last ten payload bits carry a CRC-10 computed over the whole payload, with those ten bits taken as zero.

After the last octet, the block emits a one-cycle status record. The record gives:
- the destination queue,
- whether the single-buffer option was used,
- whether the descriptor's option fields are inconsistent with a single-buffer raw cell,
- the OAM class of the cell that was sent.

Top module: `oam_cell_gen`

## Requirements
- R1: After reset `desc_ready_o` is 1, and `out_valid_o`, `pl_ready_o` and `stat_valid_o` are 0.
- R2: Each accepted descriptor yields exactly 52 output octets. `out_sop_o` is 1 on the first octet only. Header octet k carries template bits [31-8k:24-8k].
- R3: With `hdr_mod_i` = 0, the four header octets equal the template unchanged.
- R4: With `hdr_mod_i` = 1, header bits [19:4] (VCI) become `vci_data_i` and bits [3:1] (PTI) become `pti_data_i`. Bits [31:20] and bit 0 are kept.
- R5: Exactly 48 payload octets are consumed per cell. With `crc_en_i` = 0 they are forwarded unchanged.
- R6: With `crc_en_i` = 1, the first 374 payload bits are forwarded unchanged. Bits [1:0] of payload octet 46 and all of octet 47 are replaced by a CRC-10 (polynomial x^10+x^9+x^5+x^4+x+1, MSB first). The CRC is the remainder of the payload, with those 10 bits set to zero, divided by the polynomial, so the emitted payload is divisible by the polynomial.
- R7: `stat_valid_o` pulses for one cycle, in the cycle after the last octet is accepted. `stat_qid_o` is `oam_qid_i` if `oam_stat_i` was 1 at descriptor acceptance, otherwise `chan_qid_i`.
- R8: `stat_single_o` is 1 exactly when the descriptor's buffer option was 2'b01.
- R9: `stat_fmt_err_o` is 1 when the buffer option is not 2'b01, the mode is not 2'b01 (raw cell), or either message-boundary bit is set.
- R10: `stat_class_o` is derived from the emitted header, with VCI taking precedence over PTI. The codes are: 1 when VCI = 3, 2 when VCI = 4, 3 when PTI = 3'b100, 4 when PTI = 3'b101, otherwise 0.
- R11: `pl_ready_o` is never 1 while `out_ready_i` is 0. Output holds under backpressure. A descriptor offered while a cell is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor accepted when high with valid |
| hdr_i | input | 32 | Header template {GFC, VPI, VCI, PTI, CLP} |
| aal_opt_i | input | 2 | Buffer option, 2'b01 = single buffer |
| aal_mode_i | input | 2 | Adaptation mode, 2'b01 = raw cell |
| bom_i | input | 1 | Begin-of-message bit |
| eom_i | input | 1 | End-of-message bit |
| hdr_mod_i | input | 1 | Enable VCI/PTI rewrite |
| vci_data_i | input | 16 | Replacement VCI |
| pti_data_i | input | 3 | Replacement PTI |
| crc_en_i | input | 1 | Insert CRC-10 |
| oam_stat_i | input | 1 | Route status to the OAM queue |
| chan_qid_i | input | QID_W | Channel status queue |
| oam_qid_i | input | QID_W | Dedicated OAM status queue (control setting) |
| pl_valid_i | input | 1 | Payload octet valid |
| pl_data_i | input | 8 | Payload octet |
| pl_ready_o | output | 1 | Payload octet taken |
| out_valid_o | output | 1 | Output octet valid |
| out_data_o | output | 8 | Output octet |
| out_sop_o | output | 1 | First octet of cell |
| out_ready_i | input | 1 | Downstream ready |
| stat_valid_o | output | 1 | Status record pulse |
| stat_qid_o | output | QID_W | Status destination queue |
| stat_single_o | output | 1 | Single-buffer option used |
| stat_fmt_err_o | output | 1 | Inconsistent option fields |
| stat_class_o | output | 3 | OAM class of emitted header |

## Verification
The sweep covers five header cases: unchanged template, F4 segment, F4 end-to-end, F5 segment and F5 end-to-end. Each is combined with CRC off and on, and with four payload patterns:
- All zero, which gives a zero CRC.
- All ones, which exercises the two masked bits.
- Incrementing, which shows octet order.
- Scrambled, which gives a generic CRC.

Each pattern has its own backpressure and payload-gap rhythm, which separates hold behaviour from data errors. Each inserted CRC is compared with a bit-serial long division and rechecked for a zero residue over the emitted payload. Two further checks use fixed descriptors. Templates that already carry OAM VCI or PTI values, with rewrite off, separate the class decode from the rewrite. Deliberately inconsistent option fields exercise the format flag and the single-buffer flag.

// File: rtl/oam_cell_pkg.sv
package oam_cell_pkg;

  localparam logic [9:0] CRC10_POLY  = 10'h233;  // x^9+x^5+x^4+x+1, x^10 implicit
  localparam logic [1:0] OPT_SINGLE  = 2'b01;
  localparam logic [1:0] MODE_RAW    = 2'b01;
  localparam logic [15:0] VCI_F4_SEG = 16'd3;
  localparam logic [15:0] VCI_F4_E2E = 16'd4;
  localparam logic [2:0]  PTI_F5_SEG = 3'b100;
  localparam logic [2:0]  PTI_F5_E2E = 3'b101;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} cell_state_e;

  typedef enum logic [2:0] {
    CLS_USER   = 3'd0,
    CLS_F4_SEG = 3'd1,
    CLS_F4_E2E = 3'd2,
    CLS_F5_SEG = 3'd3,
    CLS_F5_E2E = 3'd4
  } cell_class_e;

  typedef struct packed {
    logic        single;
    logic        fmt_err;
    cell_class_e cls;
  } stat_flags_t;

  // one octet of long division, MSB first, augmented form
  function automatic logic [9:0] crc10_byte(input logic [9:0] crc, input logic [7:0] data);
    logic [9:0] r;
    logic       fb;
    r = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = r[9];
      r  = {r[8:0], data[i]};
      if (fb) r = r ^ CRC10_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/oam_hdr_rewrite.sv
module oam_hdr_rewrite
  import oam_cell_pkg::*;
(
  input  logic [31:0]  hdr_i,
  input  logic         mod_i,
  input  logic [15:0]  vci_i,
  input  logic [2:0]   pti_i,
  output logic [31:0]  hdr_o,
  output cell_class_e  cls_o
);

  logic [15:0] vci_out;
  logic [2:0]  pti_out;

  assign vci_out = mod_i ? vci_i : hdr_i[19:4];
  assign pti_out = mod_i ? pti_i : hdr_i[3:1];
  assign hdr_o   = {hdr_i[31:20], vci_out, pti_out, hdr_i[0]};

  // F4 identified by VCI first, F5 by PTI
  always_comb begin
    if (vci_out == VCI_F4_SEG)      cls_o = CLS_F4_SEG;
    else if (vci_out == VCI_F4_E2E) cls_o = CLS_F4_E2E;
    else if (pti_out == PTI_F5_SEG) cls_o = CLS_F5_SEG;
    else if (pti_out == PTI_F5_E2E) cls_o = CLS_F5_E2E;
    else                            cls_o = CLS_USER;
  end

endmodule

// File: rtl/oam_crc10_unit.sv
module oam_crc10_unit
  import oam_cell_pkg::*;
#(
  parameter int PAY_OCTETS = 48,
  localparam int IDX_W     = $clog2(PAY_OCTETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o
);

  localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(PAY_OCTETS - 2);
  localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(PAY_OCTETS - 1);

  logic [9:0] acc_q, acc_nxt, crc_fin;
  logic [7:0] lo_q, masked;
  logic       at_hi, at_lo;

  assign at_hi = (idx_i == IDX_HI);
  assign at_lo = (idx_i == IDX_LO);

  always_comb begin
    if (at_hi)      masked = {data_i[7:2], 2'b00};
    else if (at_lo) masked = 8'h00;
    else            masked = data_i;
  end

  assign acc_nxt = crc10_byte(acc_q, masked);
  // final octet is known zero: finish the division one octet early
  assign crc_fin = crc10_byte(acc_nxt, 8'h00);

  always_comb begin
    if (at_hi)      data_o = {data_i[7:2], crc_fin[9:8]};
    else if (at_lo) data_o = lo_q;
    else            data_o = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      lo_q  <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (adv_i) begin
      acc_q <= acc_nxt;
      if (at_hi) lo_q <= crc_fin[7:0];
    end
  end

endmodule

// File: rtl/oam_stat_route.sv
module oam_stat_route
  import oam_cell_pkg::*;
#(
  parameter int QID_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             emit_i,
  input  logic             oam_stat_i,
  input  logic [QID_W-1:0] chan_qid_i,
  input  logic [QID_W-1:0] oam_qid_i,
  input  logic [1:0]       opt_i,
  input  logic [1:0]       mode_i,
  input  logic             bom_i,
  input  logic             eom_i,
  input  cell_class_e      cls_i,
  output logic             valid_o,
  output logic [QID_W-1:0] qid_o,
  output stat_flags_t      flags_o
);

  logic [QID_W-1:0] qid_q;
  stat_flags_t      flags_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qid_q   <= '0;
      flags_q <= '{single: 1'b0, fmt_err: 1'b0, cls: CLS_USER};
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit_i;
      if (load_i) begin
        qid_q           <= oam_stat_i ? oam_qid_i : chan_qid_i;
        flags_q.single  <= (opt_i == OPT_SINGLE);
        flags_q.fmt_err <= (opt_i != OPT_SINGLE) || (mode_i != MODE_RAW) || bom_i || eom_i;
        flags_q.cls     <= cls_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign qid_o   = qid_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/oam_cell_gen.sv
module oam_cell_gen
  import oam_cell_pkg::*;
#(
  parameter int QID_W      = 4,
  parameter int PAY_OCTETS = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_valid_i,
  output logic             desc_ready_o,
  input  logic [31:0]      hdr_i,
  input  logic [1:0]       aal_opt_i,
  input  logic [1:0]       aal_mode_i,
  input  logic             bom_i,
  input  logic             eom_i,
  input  logic             hdr_mod_i,
  input  logic [15:0]      vci_data_i,
  input  logic [2:0]       pti_data_i,
  input  logic             crc_en_i,
  input  logic             oam_stat_i,
  input  logic [QID_W-1:0] chan_qid_i,
  input  logic [QID_W-1:0] oam_qid_i,
  input  logic             pl_valid_i,
  input  logic [7:0]       pl_data_i,
  output logic             pl_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sop_o,
  input  logic             out_ready_i,
  output logic             stat_valid_o,
  output logic [QID_W-1:0] stat_qid_o,
  output logic             stat_single_o,
  output logic             stat_fmt_err_o,
  output logic [2:0]       stat_class_o
);

  localparam int HDR_OCTETS = 4;
  localparam int HIDX_W     = $clog2(HDR_OCTETS);
  localparam int CNT_W      = $clog2(PAY_OCTETS);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_OCTETS - 1);
  localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAY_OCTETS - 1);

  cell_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      hdr_q, hdr_rw;
  cell_class_e      cls_rw;
  logic             crc_en_q;
  logic             desc_fire, out_fire, last_fire;
  logic [7:0]       crc_data;
  logic [7:0]       hdr_bytes [HDR_OCTETS];
  stat_flags_t      flags;

  oam_hdr_rewrite u_hdr (
    .hdr_i (hdr_i),
    .mod_i (hdr_mod_i),
    .vci_i (vci_data_i),
    .pti_i (pti_data_i),
    .hdr_o (hdr_rw),
    .cls_o (cls_rw)
  );

  for (genvar g = 0; g < HDR_OCTETS; g++) begin : g_hdr_byte
    assign hdr_bytes[g] = hdr_q[8*(HDR_OCTETS-1-g) +: 8];
  end

  assign desc_ready_o = (state_q == ST_IDLE);
  assign desc_fire    = desc_valid_i && desc_ready_o;
  assign out_valid_o  = (state_q == ST_HDR) || ((state_q == ST_PAY) && pl_valid_i);
  assign pl_ready_o   = (state_q == ST_PAY) && out_ready_i;
  assign out_fire     = out_valid_o && out_ready_i;
  assign last_fire    = out_fire && (state_q == ST_PAY) && (cnt_q == PAY_LAST);
  assign out_sop_o    = (state_q == ST_HDR) && (cnt_q == '0);

  always_comb begin
    if (state_q == ST_HDR) out_data_o = hdr_bytes[cnt_q[HIDX_W-1:0]];
    else if (crc_en_q)     out_data_o = crc_data;
    else                   out_data_o = pl_data_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (desc_valid_i) begin
        state_d = ST_HDR;
        cnt_d   = '0;
      end
      ST_HDR: if (out_fire) begin
        if (cnt_q == HDR_LAST) begin
          state_d = ST_PAY;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAY: if (out_fire) begin
        if (cnt_q == PAY_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hdr_q    <= '0;
      crc_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (desc_fire) begin
        hdr_q    <= hdr_rw;
        crc_en_q <= crc_en_i;
      end
    end
  end

  oam_crc10_unit #(.PAY_OCTETS(PAY_OCTETS)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (desc_fire),
    .adv_i  (out_fire && (state_q == ST_PAY)),
    .idx_i  (cnt_q),
    .data_i (pl_data_i),
    .data_o (crc_data)
  );

  oam_stat_route #(.QID_W(QID_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (desc_fire),
    .emit_i     (last_fire),
    .oam_stat_i (oam_stat_i),
    .chan_qid_i (chan_qid_i),
    .oam_qid_i  (oam_qid_i),
    .opt_i      (aal_opt_i),
    .mode_i     (aal_mode_i),
    .bom_i      (bom_i),
    .eom_i      (eom_i),
    .cls_i      (cls_rw),
    .valid_o    (stat_valid_o),
    .qid_o      (stat_qid_o),
    .flags_o    (flags)
  );

  assign stat_single_o  = flags.single;
  assign stat_fmt_err_o = flags.fmt_err;
  assign stat_class_o   = flags.cls;

endmodule

// File: rtl/oam_cell_gen_chk.sv
module oam_cell_gen_chk #(
  parameter int PAY_OCTETS = 48
) (
  input logic clk_i,
  input logic rst_ni,
  input logic desc_ready_o,
  input logic pl_ready_o,
  input logic out_valid_o,
  input logic out_sop_o,
  input logic out_ready_i,
  input logic stat_valid_o,
  input logic stat_single_o,
  input logic stat_fmt_err_o
);

  localparam int CELL_OCTETS = PAY_OCTETS + 4;
  localparam int BEAT_W      = $clog2(CELL_OCTETS);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(CELL_OCTETS - 1);

  logic [BEAT_W-1:0] beat_q;
  logic              fire;

  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   beat_q <= '0;
    else if (fire) beat_q <= (beat_q == BEAT_LAST) ? '0 : beat_q + 1'b1;
  end

  assert_sop_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && out_sop_o) |-> (beat_q == '0));

  assert_sop_only_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !out_sop_o) |-> (beat_q != '0));

  assert_stat_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> ($past(fire) && beat_q == '0));

  assert_stat_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);

  assert_not_single_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && !stat_single_o) |-> stat_fmt_err_o);

  assert_pl_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_ready_o |-> (out_ready_i && !desc_ready_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |-> (!out_valid_o && !pl_ready_o));

endmodule

bind oam_cell_gen oam_cell_gen_chk #(.PAY_OCTETS(PAY_OCTETS)) u_chk (.*);

// File: tb/oam_cell_gen_tb_top.sv
module oam_cell_gen_tb_top;

  localparam int QW   = 4;
  localparam int PAY  = 48;
  localparam int CELL = PAY + 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          desc_valid_i = 1'b0;
  logic          desc_ready_o;
  logic [31:0]   hdr_i = '0;
  logic [1:0]    aal_opt_i = '0;
  logic [1:0]    aal_mode_i = '0;
  logic          bom_i = 1'b0, eom_i = 1'b0, hdr_mod_i = 1'b0;
  logic [15:0]   vci_data_i = '0;
  logic [2:0]    pti_data_i = '0;
  logic          crc_en_i = 1'b0, oam_stat_i = 1'b0;
  logic [QW-1:0] chan_qid_i = '0, oam_qid_i = '0;
  logic          pl_valid_i = 1'b0;
  logic [7:0]    pl_data_i = '0;
  logic          pl_ready_o;
  logic          out_valid_o;
  logic [7:0]    out_data_o;
  logic          out_sop_o;
  logic          out_ready_i = 1'b0;
  logic          stat_valid_o;
  logic [QW-1:0] stat_qid_o;
  logic          stat_single_o, stat_fmt_err_o;
  logic [2:0]    stat_class_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  oam_cell_gen #(.QID_W(QW), .PAY_OCTETS(PAY)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(input int pat, input int i);
    case (pat)
      0:       return 8'h00;
      1:       return 8'hFF;
      2:       return 8'(i);
      default: return 8'((i * 37 + 11) ^ (i >> 1) ^ 8'h5A);
    endcase
  endfunction

  // bit-serial division over the packed payload, MSB of octet 0 first
  function automatic logic [9:0] ref_div(input logic [8*PAY-1:0] pv, input int nbits);
    logic [9:0] r = '0;
    logic       fb, b;
    for (int k = 0; k < 8*PAY; k++) begin
      b  = (k < nbits) ? pv[8*PAY-1-k] : 1'b0;
      fb = r[9];
      r  = {r[8:0], b};
      if (fb) r = r ^ 10'b10_0011_0011;
    end
    return r;
  endfunction

  function automatic logic [2:0] ref_class(input logic [31:0] h);
    if (h[19:4] == 16'd3)      return 3'd1;
    if (h[19:4] == 16'd4)      return 3'd2;
    if (h[3:1] == 3'b100)      return 3'd3;
    if (h[3:1] == 3'b101)      return 3'd4;
    return 3'd0;
  endfunction

  task automatic run_cell(input logic [31:0] hdr, input logic [1:0] opt, input logic [1:0] mode,
                          input logic bom, input logic eom, input logic hmod,
                          input logic [15:0] vci, input logic [2:0] pti,
                          input logic crc, input logic ost, input int pat);
    logic [7:0]      pay [PAY];
    logic [7:0]      epay [PAY];
    logic [7:0]      got [CELL];
    logic            gsop [CELL];
    logic [8*PAY-1:0] pv, gv;
    logic [31:0]     ehdr, ghdr;
    logic [9:0]      c10;
    logic [QW-1:0]   cq, oq, sq;
    logic            ss, se, done;
    logic [2:0]      sc;
    int ocnt, pi, cyc, bad_sop, bad_pay, bad_hold;
    ocnt = 0; pi = 0; cyc = 0; bad_sop = 0; bad_pay = 0; bad_hold = 0; done = 1'b0;
    sq = '0; ss = 1'b0; se = 1'b0; sc = '0;
    cq = QW'(pat + 3);
    oq = 4'hE;
    for (int i = 0; i < PAY; i++) begin
      pay[i] = pay_byte(pat, i);
      pv[8*(PAY-1-i) +: 8] = pay[i];
      epay[i] = pay[i];
    end
    if (crc) begin
      c10 = ref_div(pv, 8*PAY - 10);
      epay[PAY-2] = {pay[PAY-2][7:2], c10[9:8]};
      epay[PAY-1] = c10[7:0];
    end
    ehdr = hmod ? {hdr[31:20], vci, pti, hdr[0]} : hdr;

    @(negedge clk_i);
    hdr_i = hdr; aal_opt_i = opt; aal_mode_i = mode; bom_i = bom; eom_i = eom;
    hdr_mod_i = hmod; vci_data_i = vci; pti_data_i = pti; crc_en_i = crc;
    oam_stat_i = ost; chan_qid_i = cq; oam_qid_i = oq; desc_valid_i = 1'b1;
    out_ready_i = 1'b0; pl_valid_i = 1'b0;
    @(negedge clk_i);
    // pattern 3 keeps offering a different descriptor while busy (R11)
    if (pat == 3) begin
      hdr_i = ~hdr; vci_data_i = ~vci; oam_stat_i = ~ost;
    end else begin
      desc_valid_i = 1'b0;
    end

    while (!done && cyc < 2000) begin
      case (pat)
        0: out_ready_i = 1'b1;
        1: out_ready_i = (cyc % 3) != 2;
        2: out_ready_i = (cyc % 2) == 0;
        default: out_ready_i = (cyc % 5) < 3;
      endcase
      pl_valid_i = (pat == 2) ? ((cyc % 4) != 1) : 1'b1;
      pl_data_i  = pay[(pi < PAY) ? pi : PAY-1];
      #1;
      if (!out_ready_i && pl_ready_o) bad_hold++;
      if (stat_valid_o) begin
        sq = stat_qid_o; ss = stat_single_o; se = stat_fmt_err_o; sc = stat_class_o;
        done = 1'b1;
        desc_valid_i = 1'b0;
        out_ready_i  = 1'b0;
        pl_valid_i   = 1'b0;
      end else begin
        if (desc_ready_o) bad_hold++;
        if (out_valid_o && out_ready_i) begin
          if (ocnt < CELL) begin
            got[ocnt]  = out_data_o;
            gsop[ocnt] = out_sop_o;
          end
          ocnt++;
        end
        if (pl_valid_i && pl_ready_o) pi++;
        @(negedge clk_i);
        cyc++;
      end
    end

    chk(ocnt == CELL, "R2 octet count", 64'(ocnt), 64'(CELL));
    for (int k = 0; k < CELL && k < ocnt; k++)
      if (gsop[k] != (k == 0)) bad_sop++;
    chk(bad_sop == 0, "R2 sop placement", 64'(bad_sop), 64'd0);
    ghdr = {got[0], got[1], got[2], got[3]};
    chk(ghdr == ehdr, hmod ? "R4 rewritten header" : "R3 passthrough header", 64'(ghdr), 64'(ehdr));
    chk(pi == PAY, "R5 payload octets consumed", 64'(pi), 64'(PAY));
    for (int i = 0; i < PAY; i++) begin
      gv[8*(PAY-1-i) +: 8] = got[4+i];
      if (got[4+i] != epay[i]) bad_pay++;
    end
    chk(bad_pay == 0, crc ? "R6 payload with CRC-10" : "R5 payload passthrough",
        64'(bad_pay), 64'd0);
    if (crc) chk(ref_div(gv, 8*PAY) == 10'd0, "R6 zero residue", 64'(ref_div(gv, 8*PAY)), 64'd0);
    chk(sq == (ost ? oq : cq), "R7 status queue", 64'(sq), 64'(ost ? oq : cq));
    chk(ss == (opt == 2'b01), "R8 single flag", 64'(ss), 64'(opt == 2'b01));
    chk(se == ((opt != 2'b01) || (mode != 2'b01) || bom || eom), "R9 format flag",
        64'(se), 64'((opt != 2'b01) || (mode != 2'b01) || bom || eom));
    chk(sc == ref_class(ehdr), "R10 class", 64'(sc), 64'(ref_class(ehdr)));
    chk(bad_hold == 0, "R11 gating and busy", 64'(bad_hold), 64'd0);
    @(negedge clk_i);
    chk(!stat_valid_o && desc_ready_o && !out_valid_o, "R7 single-cycle status",
        64'({stat_valid_o, desc_ready_o, out_valid_o}), 64'b010);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] base;
    logic [15:0] ov_vci [5];
    logic [2:0]  ov_pti [5];
    base = {4'h5, 8'h2A, 16'h1234, 3'b010, 1'b1};
    ov_vci = '{16'h0000, 16'd3, 16'd4, 16'h0021, 16'h0021};
    ov_pti = '{3'b000, 3'b000, 3'b000, 3'b100, 3'b101};

    repeat (3) @(negedge clk_i);
    #1;
    chk(desc_ready_o && !out_valid_o && !pl_ready_o && !stat_valid_o, "R1 reset state",
        64'({desc_ready_o, out_valid_o, pl_ready_o, stat_valid_o}), 64'b1000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(desc_ready_o && !out_valid_o && !pl_ready_o && !stat_valid_o, "R1 after release",
        64'({desc_ready_o, out_valid_o, pl_ready_o, stat_valid_o}), 64'b1000);

    // five header cases x CRC x four payload and backpressure patterns
    for (int m = 0; m < 5; m++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 4; p++)
          run_cell(base, 2'b01, 2'b01, 1'b0, 1'b0, m != 0, ov_vci[m], ov_pti[m],
                   c[0], p[0] ^ c[0], p);

    // class taken from template when rewrite is off (R3, R10)
    run_cell({4'h0, 8'h01, 16'd3, 3'b101, 1'b0}, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0,
             16'hFFFF, 3'b111, 1'b1, 1'b0, 2);
    run_cell({4'h0, 8'h01, 16'h0100, 3'b101, 1'b0}, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0,
             16'd4, 3'b100, 1'b0, 1'b1, 3);
    // inconsistent option fields (R8, R9)
    run_cell(base, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 16'd4, 3'b000, 1'b1, 1'b1, 1);
    run_cell(base, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 16'd0, 3'b000, 1'b0, 1'b0, 0);
    run_cell(base, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0021, 3'b100, 1'b1, 1'b0, 3);
    run_cell(base, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 16'd0, 3'b000, 1'b0, 1'b1, 2);
    run_cell(base, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 16'd3, 3'b101, 1'b1, 1'b0, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule